// File: doc/BRIEF.md
# Prescaled Timer with Phase-Sampled Synchronizer

This block is a 16-bit up-counting timer clocked by the oscillator clock. A 2-bit phase counter splits each instruction cycle into four quarter phases, Q1 to Q4. The count source is either an internal tick at instruction rate or an external pin whose active edge software picks. The source feeds a power-of-two prescaler with a 4-bit ratio code, from 1:1 up to 1:256.

The prescaler output is not used as a clock. It is sampled at two fixed phases of every instruction cycle, Q2 and Q4, and each low-to-high change between two samples advances the counter by one. Prescaler pulses that fall wholly between two samples are therefore lost. An external edge reaches the count after a short, bounded delay.

A wrap from all ones to zero raises an overflow flag. The flag drives an interrupt request when the enable input is set, and an acknowledge input clears it. Software can load either byte of the count. A load wins over a same-cycle increment and restarts the prescaler.

Top module: `prescaled_sync_timer`

## Requirements
- R1: While `rst_n` is low and after it is released, `count` is 0, `ovf_flag` and `irq` are 0, and `phase` is 0 (Q1) until the first clock edge with `rst_n` high.
- R2: `phase` steps 0,1,2,3,0 (Q1..Q4) on every clock edge; with `src_int`=1 and `pre_sel`=0 the count rises by exactly one per four clocks.
- R3: With `src_int`=0 and ratio 1:1, `edge_rise`=1 counts low-to-high changes of `ext_in` and `edge_rise`=0 counts high-to-low changes; the opposite edge leaves the count unchanged.
- R4: `pre_sel` code k from 0 to 8 gives one increment per 2^k source edges; codes 9 to 15 behave as code 8 (1:256).
- R5: Without a write, the count changes only at a clock edge that ends a Q2 or Q4 cycle (`phase` 1 or 3), and then by exactly +1.
- R6: At 1:1 with the external source, a one-clock pin pulse whose synchronized copy falls into a Q1 or Q3 cycle causes no increment; the same pulse landing in Q2 or Q4 causes one.
- R7: At 1:1 with the external source, an active pin change made mid-cycle shows on `count` after the third or fourth rising clock edge that follows it.
- R8: A wrap from FFFFh to 0000h sets `ovf_flag`; it stays set until a clock edge with `irq_ack`=1 and no wrap; a wrap in the same cycle as `irq_ack` leaves the flag set.
- R9: `irq` is 1 exactly when `ovf_flag` and `irq_en` are both 1.
- R10: `wr_be[0]` loads `wr_data` into count bits 7:0 and `wr_be[1]` into bits 15:8 at the next edge; any write suppresses that cycle's increment and clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_in | input | 1 | Asynchronous external count pin |
| src_int | input | 1 | 1: internal instruction tick, 0: external pin |
| edge_rise | input | 1 | External active edge, 1 rising, 0 falling |
| pre_sel | input | 4 | Prescale code, ratio 2^min(code,8) |
| wr_be | input | 2 | Byte write enables, bit 0 low byte, bit 1 high byte |
| wr_data | input | 8 | Byte write data |
| irq_en | input | 1 | Interrupt request enable |
| irq_ack | input | 1 | Vector acknowledge, clears the flag |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Gated interrupt request |
| phase | output | 2 | Current quarter phase, 0 = Q1 |

## Verification
The bench places pin pulses one clock wide at each starting phase. A synchronizer that sampled the raw pin, or sampled on every clock, would count the pulses that should be lost. It also times the pin-to-count delay from every phase, so an extra or a missing register stage shows up as an off-by-one latency. Long runs at codes 8 and 12 expose a ratio decode that does not clamp. A write placed in the Q4 cycle, where an increment is due, catches a design that lets the increment through. A wrap with the acknowledge held high catches a flag that is cleared when it should have been set.

// File: rtl/pst_pkg.sv
package pst_pkg;
   localparam logic [1:0] PH_Q1 = 2'd0;
   localparam logic [1:0] PH_Q2 = 2'd1;
   localparam logic [1:0] PH_Q3 = 2'd2;
   localparam logic [1:0] PH_Q4 = 2'd3;

   // Ratio code clamp: codes past the divider depth select the last stage.
   function automatic int unsigned eff_stage(input int unsigned code,
                                             input int unsigned stages);
      return (code > stages) ? stages : code;
   endfunction
endpackage

// File: rtl/pst_phase_gen.sv
module pst_phase_gen
   import pst_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   output logic [1:0] phase,
   output logic       sample_stb,
   output logic       int_level
);
   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_Q1;
      else        phase <= phase + 2'd1;
   end

   // The prescaler output is sampled in the Q2 and Q4 cycles.
   assign sample_stb = (phase == PH_Q2) || (phase == PH_Q4);
   // Internal tick: low in Q1/Q2, high in Q3/Q4, one rise per cycle.
   assign int_level  = phase[1];
endmodule

// File: rtl/pst_prescaler.sv
module pst_prescaler
   import pst_pkg::*;
#(
   parameter int STAGES      = 8,
   parameter int SEL_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_in,
   input  logic             src_int,
   input  logic             edge_rise,
   input  logic             int_level,
   input  logic [SEL_W-1:0] sel,
   input  logic             clr,
   output logic             psout
);
   localparam int IDX_W = $clog2(STAGES);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pst_prescaler: STAGES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pst_prescaler: SYNC_STAGES must be at least 2");
      end
      if ((2 ** SEL_W) - 1 < STAGES) begin : g_bad_sel
         $error("pst_prescaler: SEL_W too narrow for STAGES");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_s;
   logic                   src;
   logic                   src_q;
   logic [STAGES-1:0]      div_q;
   logic [IDX_W-1:0]       tap;
   int unsigned            k;

   // Metastability guard on the pin before edge qualification.
   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
   end
   assign ext_s = sync_q[SYNC_STAGES-1];

   // Edge-qualified source: its rising edge is always the active event.
   assign src = src_int ? int_level : (edge_rise ? ext_s : ~ext_s);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         div_q <= '0;
      end else begin
         src_q <= src;
         if (clr)                div_q <= '0;
         else if (src && !src_q) div_q <= div_q + 1'b1;
      end
   end

   always_comb begin
      k     = eff_stage(int'(sel), STAGES);
      tap   = (k == 0) ? '0 : IDX_W'(k - 1);
      psout = (k == 0) ? src : div_q[tap];
   end
endmodule

// File: rtl/pst_sampler.sv
module pst_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_stb,
   input  logic psout,
   output logic inc
);
   logic smp_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          smp_q <= 1'b0;
      else if (sample_stb) smp_q <= psout;
   end

   // A low sample followed by a high sample is one count event.
   assign inc = sample_stb & psout & ~smp_q;
endmodule

// File: rtl/pst_counter.sv
module pst_counter #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   localparam int NB    = CNT_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic [NB-1:0]     wr_be,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              ack,
   output logic [CNT_W-1:0]  count,
   output logic              ovf
);
   logic             wr_any;
   logic             step;
   logic             wrap;
   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] nxt;

   assign wr_any = |wr_be;
   assign step   = inc & ~wr_any;
   assign wrap   = step & (&count);
   assign base   = step ? count + CNT_W'(1) : count;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_byte
         assign nxt[b*BYTE_W +: BYTE_W] = wr_be[b] ? wr_data : base[b*BYTE_W +: BYTE_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         count <= nxt;
         if (wrap)     ovf <= 1'b1;
         else if (ack) ovf <= 1'b0;
      end
   end
endmodule

// File: rtl/prescaled_sync_timer.sv
module prescaled_sync_timer #(
   parameter int CNT_W       = 16,
   parameter int BYTE_W      = 8,
   parameter int PRE_STAGES  = 8,
   parameter int SEL_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int NB         = CNT_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_in,
   input  logic              src_int,
   input  logic              edge_rise,
   input  logic [SEL_W-1:0]  pre_sel,
   input  logic [NB-1:0]     wr_be,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              irq_en,
   input  logic              irq_ack,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_flag,
   output logic              irq,
   output logic [1:0]        phase
);
   generate
      if ((CNT_W % BYTE_W) != 0 || NB < 1) begin : g_bad_width
         $error("prescaled_sync_timer: CNT_W must be a multiple of BYTE_W");
      end
   endgenerate

   logic sample_stb;
   logic int_level;
   logic psout;
   logic inc;

   pst_phase_gen u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .sample_stb (sample_stb),
      .int_level  (int_level)
   );

   pst_prescaler #(
      .STAGES      (PRE_STAGES),
      .SEL_W       (SEL_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_in    (ext_in),
      .src_int   (src_int),
      .edge_rise (edge_rise),
      .int_level (int_level),
      .sel       (pre_sel),
      .clr       (|wr_be),
      .psout     (psout)
   );

   pst_sampler u_samp (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .psout      (psout),
      .inc        (inc)
   );

   pst_counter #(
      .CNT_W  (CNT_W),
      .BYTE_W (BYTE_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc),
      .wr_be   (wr_be),
      .wr_data (wr_data),
      .ack     (irq_ack),
      .count   (count),
      .ovf     (ovf_flag)
   );

   assign irq = ovf_flag & irq_en;
endmodule

// File: rtl/pst_chk.sv
module pst_chk #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   localparam int NB    = CNT_W / BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NB-1:0]     wr_be,
   input logic [BYTE_W-1:0] wr_data,
   input logic              irq_en,
   input logic              irq_ack,
   input logic [CNT_W-1:0]  count,
   input logic              ovf_flag,
   input logic              irq,
   input logic [1:0]        phase
);
   assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (phase == $past(phase) + 2'd1));

   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(wr_be) == '0)) |->
         ((count == $past(count)) || (count == $past(count) + CNT_W'(1))));

   assert_sample_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(wr_be) == '0) && (count != $past(count))) |->
         ($past(phase) == 2'd1 || $past(phase) == 2'd3));

   assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (count == '0));

   assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(irq_ack) && (count != '0)) |-> !ovf_flag);

   assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf_flag && irq_en));

   assert_lo_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_be[0])) |-> (count[BYTE_W-1:0] == $past(wr_data)));
endmodule

bind prescaled_sync_timer pst_chk #(
   .CNT_W  (CNT_W),
   .BYTE_W (BYTE_W)
) u_chk (.*);

// File: tb/sim_prescaled_sync_timer.sv
module sim_prescaled_sync_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk;
   logic        rst_n;
   logic        ext_in;
   logic        src_int;
   logic        edge_rise;
   logic [3:0]  pre_sel;
   logic [1:0]  wr_be;
   logic [7:0]  wr_data;
   logic        irq_en;
   logic        irq_ack;
   logic [15:0] count;
   logic        ovf_flag;
   logic        irq;
   logic [1:0]  phase;

   int n_tests = 0;
   int n_fail  = 0;

   prescaled_sync_timer u0 (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .src_int(src_int),
      .edge_rise(edge_rise), .pre_sel(pre_sel), .wr_be(wr_be),
      .wr_data(wr_data), .irq_en(irq_en), .irq_ack(irq_ack),
      .count(count), .ovf_flag(ovf_flag), .irq(irq), .phase(phase)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Behavioural reference: pin delay line, source edge tally, twice-per-cycle sampling.
   int m_pin[$];
   int m_src_prev, m_tally, m_ph, m_last_smp, m_cnt, m_flag;

   always @(posedge clk) begin
      int s, ps, k, do_inc, wr;
      if (!rst_n) begin
         m_pin = {0, 0};
         m_src_prev = 0; m_tally = 0; m_ph = 0; m_last_smp = 0; m_cnt = 0; m_flag = 0;
      end else begin
         if (src_int) s = (m_ph >= 2) ? 1 : 0;
         else         s = edge_rise ? m_pin[0] : 1 - m_pin[0];
         k  = (pre_sel > 8) ? 8 : int'(pre_sel);
         ps = (k == 0) ? s : ((m_tally >> (k - 1)) & 1);
         wr = (wr_be != 2'b00) ? 1 : 0;
         do_inc = ((m_ph == 1 || m_ph == 3) && ps == 1 && m_last_smp == 0) ? 1 : 0;
         if (do_inc == 1 && wr == 0 && m_cnt == 65535) m_flag = 1;
         else if (irq_ack) m_flag = 0;
         if (wr == 1) begin
            if (wr_be[0]) m_cnt = (m_cnt & 'hFF00) | int'(wr_data);
            if (wr_be[1]) m_cnt = (m_cnt & 'h00FF) | (int'(wr_data) << 8);
         end else if (do_inc == 1) begin
            m_cnt = (m_cnt + 1) % 65536;
         end
         if (wr == 1) m_tally = 0;
         else if (s == 1 && m_src_prev == 0) m_tally = (m_tally + 1) % 256;
         if (m_ph == 1 || m_ph == 3) m_last_smp = ps;
         m_src_prev = s;
         void'(m_pin.pop_front());
         m_pin.push_back(ext_in ? 1 : 0);
         m_ph = (m_ph + 1) % 4;
      end
      #1;
      if (rst_n) begin
         chk("R5 count vs model", int'(count), m_cnt);
         chk("R8 flag vs model", int'(ovf_flag), m_flag);
         chk("R9 irq vs model", int'(irq), (m_flag == 1 && irq_en) ? 1 : 0);
         chk("R2 phase vs model", int'(phase), m_ph);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input logic [1:0] be, input logic [7:0] d);
      wr_be = be; wr_data = d;
      tick(1);
      wr_be = 2'b00;
   endtask

   task automatic wait_phase(input int p);
      while (int'(phase) != p) tick(1);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
   end

   initial begin
      int c0, n, hi;
      rst_n = 1'b0; ext_in = 1'b0; src_int = 1'b1; edge_rise = 1'b1; pre_sel = 4'd0;
      wr_be = 2'b00; wr_data = 8'h00; irq_en = 1'b0; irq_ack = 1'b0;
      tick(3);
      // R1 reset state
      chk("R1 count at reset", int'(count), 0);
      chk("R1 flag at reset", int'(ovf_flag), 0);
      chk("R1 irq at reset", int'(irq), 0);
      chk("R1 phase at reset", int'(phase), 0);
      rst_n = 1'b1;
      tick(1);
      chk("R1 count after release", int'(count), 0);

      // R2 internal tick at 1:1
      c0 = int'(count);
      tick(40);
      chk("R2 internal 1:1 increments in 40 clocks", int'(count) - c0, 10);

      // R4 ratios, each started by a load that clears the prescaler (R10)
      pre_sel = 4'd2;
      load(2'b11, 8'h00);
      chk("R10 load both bytes", int'(count), 0);
      tick(64);
      chk("R4 code 2 increments in 64 clocks", int'(count), 4);
      pre_sel = 4'd8;
      load(2'b11, 8'h00);
      tick(2048);
      chk("R4 code 8 increments in 2048 clocks", int'(count), 2);
      pre_sel = 4'd12;
      load(2'b11, 8'h00);
      tick(2048);
      chk("R4 code 12 clamps to 1:256", int'(count), 2);

      // R3 external pin, both edge choices
      pre_sel = 4'd0; src_int = 1'b0; edge_rise = 1'b1; ext_in = 1'b0;
      tick(8);
      c0 = int'(count);
      for (int i = 0; i < 10; i++) begin
         ext_in = 1'b1; tick(4);
         ext_in = 1'b0; tick(4);
      end
      tick(6);
      chk("R3 rising edges counted", int'(count) - c0, 10);
      edge_rise = 1'b0;
      tick(8);
      c0 = int'(count);
      ext_in = 1'b1; tick(8);
      chk("R3 rising edge ignored in falling mode", int'(count) - c0, 0);
      ext_in = 1'b0; tick(8);
      chk("R3 falling edge counted", int'(count) - c0, 1);
      edge_rise = 1'b1;
      tick(8);

      // R6 one-clock pulses: lost when the synchronized copy lands in Q3, kept in Q4
      wait_phase(0);
      c0 = int'(count);
      ext_in = 1'b1; tick(1); ext_in = 1'b0; tick(8);
      chk("R6 short pulse missed", int'(count) - c0, 0);
      wait_phase(1);
      c0 = int'(count);
      ext_in = 1'b1; tick(1); ext_in = 1'b0; tick(8);
      chk("R6 short pulse caught", int'(count) - c0, 1);

      // R7 pin-to-count latency from every starting phase
      for (int a = 0; a < 4; a++) begin
         wait_phase(a);
         c0 = int'(count);
         ext_in = 1'b1;
         n = 0;
         while (int'(count) == c0 && n < 9) begin
            tick(1);
            n++;
         end
         chk($sformatf("R7 latency from phase %0d", a), n, (a % 2 == 1) ? 3 : 4);
         ext_in = 1'b0;
         tick(8);
      end

      // R8 / R9 overflow and gating
      src_int = 1'b1;
      load(2'b11, 8'hFF);
      chk("R10 load FFFFh", int'(count), 65535);
      n = 0;
      while (int'(count) != 0 && n < 8) begin tick(1); n++; end
      chk("R8 wrap to zero", int'(count), 0);
      chk("R8 wrap sets flag", int'(ovf_flag), 1);
      chk("R9 irq masked", int'(irq), 0);
      irq_en = 1'b1; tick(1);
      chk("R9 irq enabled", int'(irq), 1);
      irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
      chk("R8 ack clears flag", int'(ovf_flag), 0);
      chk("R9 irq drops with flag", int'(irq), 0);

      load(2'b11, 8'hFF);
      irq_ack = 1'b1;
      n = 0;
      while (int'(count) != 0 && n < 8) begin tick(1); n++; end
      chk("R8 wrap beats held ack", int'(ovf_flag), 1);
      tick(1);
      chk("R8 held ack then clears", int'(ovf_flag), 0);
      irq_ack = 1'b0;

      // R10 write beats an increment due in the same cycle
      wait_phase(3);
      hi = int'(count) >> 8;
      load(2'b01, 8'h55);
      chk("R10 low write beats increment", int'(count), (hi << 8) | 'h55);
      load(2'b10, 8'hA0);
      chk("R10 high byte write", int'(count) >> 8, 'hA0);

      tick(4);
      finish_run();
   end
endmodule